// File: doc/BRIEF.md
# Watchdog Countdown with Byte-Coded Timeout

The block is a watchdog counter steered by one control byte. The byte packs three fields: a five-bit multiplier, a two-bit resolution code and a steering bit. The timeout equals the multiplier times the resolution. The counter runs from an external time-base tick that pulses sixteen times per second.

Every nonzero write reloads the counter with the timeout that the new byte encodes. That write is the keep-alive, so a host that stops writing lets the count run out. A write of zero disarms the watchdog, and so does a byte whose multiplier field is zero. When the count runs out, a one-cycle pulse leaves on the reset output or on the interrupt output, depending on the steering bit. The counter then stays idle until the next write.

Top module: `rtc_wdog`

## Requirements
- R1: After reset the control byte reads 0x00, both pulse outputs are low and the counter is disarmed, so ticks alone produce no pulse.
- R2: In the cycle after a write, `rd_data` returns the byte just written, and it holds that value until the next write.
- R3: The multiplier is bits 6:2 of the byte and the resolution code is bits 1:0. The codes 0, 1, 2 and 3 select 1, 4, 16 and 64 ticks, which are 1/16 s, 1/4 s, 1 s and 4 s. The timeout is the multiplier times that many ticks.
- R4: The pulse follows the tick that ends the timeout and comes in the clock cycle right after that tick's edge. It is exactly one cycle wide, and no pulse appears on any earlier tick.
- R5: Bit 7 set steers the pulse to `wd_rst`. Bit 7 clear steers it to `wd_irq`. The two outputs are never high together.
- R6: A nonzero write made while counting reloads the full timeout of the new byte, and counting restarts from the next tick.
- R7: A write of 0x00 disarms the watchdog, and no pulse follows however many ticks arrive.
- R8: A byte with a zero multiplier field also disarms the watchdog, whatever its resolution and steering bits hold.
- R9: After a pulse the watchdog stays idle, and further ticks produce no pulse until the next nonzero write.
- R10: The count changes only on a tick or a write. Cycles without a tick do not shorten the timeout.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the control byte |
| wr_data | input | 8 | Control byte to write |
| rd_data | output | 8 | Current control byte |
| tick | input | 1 | Time-base pulse, one clock wide, 16 per second |
| wd_rst | output | 1 | Timeout pulse when bit 7 was set |
| wd_irq | output | 1 | Timeout pulse when bit 7 was clear |

## Verification
Four properties are checked on every cycle: the two outputs never overlap, each pulse is one cycle wide, a pulse only follows a tick and leaves the counter idle, and the count holds while there is neither tick nor write. Read-back after a write is also checked every cycle. Only the bench scenarios can show that the decoded timeout is right for each resolution code, that a mid-count rewrite restarts the full period, and that zero bytes and zero multipliers really disarm the watchdog. Those scenarios count ticks against a model computed from the byte.

// File: rtl/rtc_wdog.sv
module rtc_wdog #(
  parameter int MULT_W = 5,
  parameter int RES_W  = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  output logic [7:0] rd_data,
  input  logic       tick,
  output logic       wd_rst,
  output logic       wd_irq
);
  localparam int MAX_SHIFT = 2 * ((1 << RES_W) - 1);
  localparam int CNT_W     = MULT_W + MAX_SHIFT;

  logic [7:0]       ctrl;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] load_val;
  logic             expire;

  assign load_val = {{MAX_SHIFT{1'b0}}, wr_data[MULT_W+1:2]} << {wr_data[RES_W-1:0], 1'b0};
  assign expire   = tick && (cnt == CNT_W'(1));
  assign rd_data  = ctrl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl   <= 8'h00;
      cnt    <= '0;
      wd_rst <= 1'b0;
      wd_irq <= 1'b0;
    end else begin
      wd_rst <= 1'b0;
      wd_irq <= 1'b0;
      if (wr_en) begin
        ctrl <= wr_data;
        cnt  <= load_val;
      end else if (tick && cnt != '0) begin
        cnt <= cnt - CNT_W'(1);
        if (expire) begin
          wd_rst <= ctrl[7];
          wd_irq <= !ctrl[7];
        end
      end
    end
  end

  a_r5_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(wd_rst && wd_irq));

  a_r4_rst_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    wd_rst |=> !wd_rst);

  a_r4_irq_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    wd_irq |=> !wd_irq);

  a_r9_idle_after_fire: assert property (@(posedge clk) disable iff (!rst_n)
    (wd_rst || wd_irq) |-> (cnt == '0 || $past(wr_en)));

  a_r4_fire_after_tick: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wd_rst || wd_irq) |-> $past(tick));

  a_r10_hold_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !wr_en) |=> $stable(cnt));

  a_r2_readback: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> rd_data == $past(wr_data));
endmodule

// File: tb/rtc_wdog_test.sv
`timescale 1ns/1ps
module rtc_wdog_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       tick = 1'b0;
  logic [7:0] rd_data;
  logic       wd_rst, wd_irq;
  int         n_chk = 0;
  int         n_bad = 0;
  bit         done = 1'b0;

  rtc_wdog uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .tick(tick), .wd_rst(wd_rst), .wd_irq(wd_irq)
  );

  always #2.5 clk = ~clk;

  function automatic int exp_ticks(input logic [7:0] b);
    return int'(b[6:2]) * (1 << (2 * int'(b[1:0])));
  endfunction

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] b);
    @(negedge clk);
    wr_en = 1'b1;
    wr_data = b;
    @(negedge clk);
    wr_en = 1'b0;
    check("R2 readback", int'(rd_data), int'(b));
  endtask

  task automatic tick1(output int r, output int i);
    @(negedge clk);
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
    r = int'(wd_rst);
    i = int'(wd_irq);
  endtask

  task automatic run_case(input logic [7:0] b, input string req);
    int n, r, i, early;
    n = exp_ticks(b);
    wr(b);
    early = 0;
    if (n == 0) begin
      for (int k = 0; k < 100; k++) begin
        tick1(r, i);
        early += r + i;
      end
      check({req, " disarmed no pulse"}, early, 0);
      return;
    end
    for (int k = 0; k < n - 1; k++) begin
      tick1(r, i);
      early += r + i;
    end
    check({req, " R3 R4 no early pulse"}, early, 0);
    tick1(r, i);
    check({req, " R4 R5 rst at timeout"}, r, int'(b[7]));
    check({req, " R4 R5 irq at timeout"}, i, int'(!b[7]));
    @(negedge clk);
    check({req, " R4 pulse width"}, int'(wd_rst) + int'(wd_irq), 0);
    early = 0;
    for (int k = 0; k < 8; k++) begin
      tick1(r, i);
      early += r + i;
    end
    check({req, " R9 no repeat"}, early, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    int r, i, early, n;
    logic [7:0] b;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset byte", int'(rd_data), 0);
    check("R1 reset outputs", int'(wd_rst) + int'(wd_irq), 0);
    early = 0;
    for (int k = 0; k < 40; k++) begin
      tick1(r, i);
      early += r + i;
    end
    check("R1 idle after reset", early, 0);

    run_case(8'h04, "R3 res0");
    run_case(8'h09, "R3 res1");
    run_case(8'h96, "R3 res2");
    run_case(8'hBF, "R3 res3");
    run_case(8'h7E, "R5 irq path");
    run_case(8'h00, "R7");
    run_case(8'h83, "R8");
    run_case(8'h02, "R8");

    // R6: rewrite mid-count restarts full period
    b = 8'h8E;
    n = exp_ticks(b);
    wr(b);
    early = 0;
    for (int k = 0; k < n - 2; k++) begin
      tick1(r, i);
      early += r + i;
    end
    wr(b);
    for (int k = 0; k < n - 1; k++) begin
      tick1(r, i);
      early += r + i;
    end
    check("R6 no pulse after reload", early, 0);
    tick1(r, i);
    check("R6 pulse at reloaded timeout", r, 1);

    // R7: zero write mid-count
    wr(8'h0D);
    for (int k = 0; k < 3; k++) tick1(r, i);
    wr(8'h00);
    early = 0;
    for (int k = 0; k < 30; k++) begin
      tick1(r, i);
      early += r + i;
    end
    check("R7 disarm mid-count", early, 0);

    // R10: idle cycles without ticks do not count
    b = 8'h0C;
    wr(b);
    repeat (60) @(negedge clk);
    check("R10 no pulse without ticks", int'(wd_rst) + int'(wd_irq), 0);
    early = 0;
    for (int k = 0; k < exp_ticks(b) - 1; k++) begin
      tick1(r, i);
      early += r + i;
    end
    check("R10 count intact", early, 0);
    tick1(r, i);
    check("R10 pulse on final tick", i, 1);

    for (int t = 0; t < 14; t++) begin
      b = 8'($urandom);
      if (b[1:0] == 2'd3) b[6:2] = b[6:2] & 5'h07;
      run_case(b, "R3 random");
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule